// File: doc/BRIEF.md
# LFSR Mixer and Post-Processor

This datapath takes a stream of raw entropy bits, one per accepted beat, and turns it into 32-bit random words. Each accepted bit is first combined with a Fibonacci LFSR of either 59 or 128 stages, using one of five output modes. The result then passes through an optional debiasing step: pass-through, bit skipping, bit counting (parity) or Von Neumann. The surviving bits are packed into a word for a register controller. The LFSR can be reseeded at any time, either from a seed vector supplied by software or from a history of the most recent raw bits.

Both data edges use valid/ready. A raw bit is accepted on a clock edge where `raw_valid` and `raw_ready` are both high. The LFSR, the mode state and the history advance only on accepted beats. A finished word is offered on `word_valid`, and it stays offered, unchanged, until `word_ready` is seen high. `raw_ready` is `!word_valid || word_ready`, so back-pressure on the word side stalls the raw side. The LFSR stays in step with the words as a result. Configuration inputs are plain levels and are used on every accepted beat. They are meant to be changed only while the stream is idle.

Top module: `rng_mixer_pp`

## Requirements
- R1: After reset, `word_valid` is 0, `raw_ready` is 1, the LFSR state is 1, and all mode, debias and packing state is cleared.
- R2: The LFSR output bit is its top stage: bit 58 in short mode (`lfsr_long`=0) or bit 127 in long mode (`lfsr_long`=1). On each accepted beat it shifts toward the top and inserts at bit 0 the XOR of taps 59,58,38,37 (short) or 128,126,101,99 (long), with taps counted from 1. It does not move without an accepted beat or a seed load.
- R3: A `seed_load` pulse loads the LFSR from the raw history when `seed_src`=4. The history holds the last 128 accepted raw bits, with the newest in bit 0. For any other `seed_src` value the load comes from `user_seed`. The value is masked to the active length, and a masked value of zero is replaced by 1.
- R4: `out_mode` 4 passes the raw bit, 8 gives LFSR XOR raw, and 9 gives the LFSR bit alone. Any code not listed here acts as 4.
- R5: `out_mode` 7 alternates between LFSR and raw on successive beats, starting with the LFSR bit after reset.
- R6: `out_mode` 6 outputs LFSR XOR raw XOR the previous mode-6 output. The previous output is 0 after reset.
- R7: `pp_mode` 0 forwards every mixed bit. `pp_mode` 1 forwards only the second, fourth, sixth and so on.
- R8: `pp_mode` 2 emits one bit per group of 4 mixed bits: the XOR of the four.
- R9: `pp_mode` 3 takes mixed bits in pairs. The pair 0 then 1 yields 0, 1 then 0 yields 1, and equal pairs yield nothing.
- R10: Emitted bits fill the word from bit 0 upward. `word_valid` rises on the cycle after the 32nd bit is accepted.
- R11: While `word_valid` is high and `word_ready` is low, `word_data` holds and `raw_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_bit | input | 1 | Raw entropy bit |
| raw_valid | input | 1 | Raw bit present |
| raw_ready | output | 1 | Raw bit accepted this edge if valid |
| out_mode | input | 4 | Combining mode (4, 6, 7, 8, 9) |
| pp_mode | input | 2 | Debias mode (0 none, 1 skip, 2 count, 3 Von Neumann) |
| lfsr_long | input | 1 | 0: 59-stage LFSR, 1: 128-stage LFSR |
| seed_src | input | 3 | 4: seed from raw history, else from user_seed |
| user_seed | input | 128 | Software seed value |
| seed_load | input | 1 | Pulse: load LFSR seed |
| word_data | output | 32 | Packed random word |
| word_valid | output | 1 | Word offered |
| word_ready | input | 1 | Word taken this edge if valid |

## Verification
The bench builds the block with its defaults: a 32-bit word, a 128-stage long LFSR and a 59-stage short LFSR. These bring both tap sets and the full history-to-seed path into reach. Each combining mode is run with a different debias mode under random raw data, random gaps in `raw_valid` and random stalls on `word_ready`. A bench-side model predicts every word. Directed phases cover an all-zero user seed, reseeding from the history, an unlisted mode code and a constant raw stream under Von Neumann, which must produce no words at all.

// File: rtl/rng_mix_pkg.sv
package rng_mix_pkg;
  localparam int LEN_SHORT = 59;
  localparam int LEN_LONG  = 128;
  localparam int WORD_W    = 32;

  typedef enum logic [3:0] {
    OM_RAW    = 4'd4,
    OM_PARITY = 4'd6,
    OM_ALT    = 4'd7,
    OM_XOR    = 4'd8,
    OM_LFSR   = 4'd9
  } out_mode_e;

  typedef enum logic [1:0] {
    PP_NONE  = 2'd0,
    PP_SKIP  = 2'd1,
    PP_COUNT = 2'd2,
    PP_VN    = 2'd3
  } pp_mode_e;

  localparam logic [2:0] SEED_FROM_RAW = 3'd4;

  // tap positions as zero-based bit indices
  localparam int S_TAP0 = 58, S_TAP1 = 57, S_TAP2 = 37, S_TAP3 = 36;
  localparam int L_TAP0 = 127, L_TAP1 = 125, L_TAP2 = 100, L_TAP3 = 98;
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr
  import rng_mix_pkg::*;
#(
  parameter int LONG_LEN  = LEN_LONG,
  parameter int SHORT_LEN = LEN_SHORT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                load,
  input  logic                long_sel,
  input  logic [LONG_LEN-1:0] seed,
  output logic [LONG_LEN-1:0] state_q,
  output logic                out_bit
);
  localparam int PAD = LONG_LEN - SHORT_LEN;

  logic [LONG_LEN-1:0] short_mask, masked, next_state;
  logic fb_short, fb_long;

  assign short_mask = {{PAD{1'b0}}, {SHORT_LEN{1'b1}}};
  assign masked     = long_sel ? seed : (seed & short_mask);

  assign fb_short = state_q[S_TAP0] ^ state_q[S_TAP1] ^ state_q[S_TAP2] ^ state_q[S_TAP3];
  assign fb_long  = state_q[L_TAP0] ^ state_q[L_TAP1] ^ state_q[L_TAP2] ^ state_q[L_TAP3];

  always_comb begin
    if (long_sel) next_state = {state_q[LONG_LEN-2:0], fb_long};
    else          next_state = {{PAD{1'b0}}, state_q[SHORT_LEN-2:0], fb_short};
  end

  assign out_bit = long_sel ? state_q[LONG_LEN-1] : state_q[SHORT_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LONG_LEN'(1);
    end else if (load) begin
      state_q <= (masked == '0) ? LONG_LEN'(1) : masked;
    end else if (step) begin
      state_q <= next_state;
    end
  end
endmodule

// File: rtl/rng_combiner.sv
module rng_combiner
  import rng_mix_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic [3:0] mode,
  input  logic       raw_bit,
  input  logic       lfsr_bit,
  output logic       mix_bit
);
  logic alt_q, prev_q;

  always_comb begin
    unique case (mode)
      OM_LFSR:   mix_bit = lfsr_bit;
      OM_XOR:    mix_bit = lfsr_bit ^ raw_bit;
      OM_ALT:    mix_bit = alt_q ? raw_bit : lfsr_bit;
      OM_PARITY: mix_bit = lfsr_bit ^ raw_bit ^ prev_q;
      default:   mix_bit = raw_bit;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q  <= 1'b0;
      prev_q <= 1'b0;
    end else if (beat) begin
      if (mode == OM_ALT)    alt_q  <= ~alt_q;
      if (mode == OM_PARITY) prev_q <= mix_bit;
    end
  end
endmodule

// File: rtl/rng_postproc.sv
module rng_postproc
  import rng_mix_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic [1:0] mode,
  input  logic       in_bit,
  output logic       emit,
  output logic       out_bit
);
  logic [1:0] cnt_q;
  logic       acc_q;

  always_comb begin
    emit    = 1'b0;
    out_bit = in_bit;
    unique case (mode)
      PP_NONE:  emit = beat;
      PP_SKIP:  emit = beat & cnt_q[0];
      PP_COUNT: begin
        emit    = beat & (cnt_q == 2'd3);
        out_bit = acc_q ^ in_bit;
      end
      PP_VN: begin
        emit    = beat & cnt_q[0] & (acc_q != in_bit);
        out_bit = acc_q;
      end
      default: emit = beat;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= 1'b0;
    end else if (beat) begin
      unique case (mode)
        PP_SKIP: cnt_q[0] <= ~cnt_q[0];
        PP_COUNT: begin
          cnt_q <= cnt_q + 2'd1;
          acc_q <= (cnt_q == 2'd3) ? 1'b0 : (acc_q ^ in_bit);
        end
        PP_VN: begin
          cnt_q[0] <= ~cnt_q[0];
          if (!cnt_q[0]) acc_q <= in_bit;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rng_packer.sv
module rng_packer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         emit,
  input  logic         bit_in,
  input  logic         word_ready,
  output logic         word_valid,
  output logic [W-1:0] word_data
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      word_data  <= '0;
      word_valid <= 1'b0;
    end else begin
      if (word_valid && word_ready) word_valid <= 1'b0;
      if (emit) begin
        word_data[cnt_q] <= bit_in;
        if (cnt_q == LAST) begin
          cnt_q      <= '0;
          word_valid <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rng_mixer_pp.sv
module rng_mixer_pp
  import rng_mix_pkg::*;
#(
  parameter int LONG_LEN  = LEN_LONG,
  parameter int SHORT_LEN = LEN_SHORT,
  parameter int W         = WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                raw_bit,
  input  logic                raw_valid,
  output logic                raw_ready,
  input  logic [3:0]          out_mode,
  input  logic [1:0]          pp_mode,
  input  logic                lfsr_long,
  input  logic [2:0]          seed_src,
  input  logic [LONG_LEN-1:0] user_seed,
  input  logic                seed_load,
  output logic [W-1:0]        word_data,
  output logic                word_valid,
  input  logic                word_ready
);
  logic                beat;
  logic [LONG_LEN-1:0] hist_q, seed_sel, lfsr_q;
  logic                lfsr_bit, mix_bit, pp_emit, pp_bit;

  assign raw_ready = !word_valid || word_ready;
  assign beat      = raw_valid && raw_ready;
  assign seed_sel  = (seed_src == SEED_FROM_RAW) ? hist_q : user_seed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hist_q <= '0;
    else if (beat) hist_q <= {hist_q[LONG_LEN-2:0], raw_bit};
  end

  rng_lfsr #(.LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(beat), .load(seed_load),
    .long_sel(lfsr_long), .seed(seed_sel), .state_q(lfsr_q), .out_bit(lfsr_bit)
  );

  rng_combiner u_mix (
    .clk(clk), .rst_n(rst_n), .beat(beat), .mode(out_mode),
    .raw_bit(raw_bit), .lfsr_bit(lfsr_bit), .mix_bit(mix_bit)
  );

  rng_postproc u_pp (
    .clk(clk), .rst_n(rst_n), .beat(beat), .mode(pp_mode),
    .in_bit(mix_bit), .emit(pp_emit), .out_bit(pp_bit)
  );

  rng_packer #(.W(W)) u_pack (
    .clk(clk), .rst_n(rst_n), .emit(pp_emit), .bit_in(pp_bit),
    .word_ready(word_ready), .word_valid(word_valid), .word_data(word_data)
  );
endmodule

// File: rtl/rng_mixer_pp_chk.sv
module rng_mixer_pp_chk #(
  parameter int LONG_LEN = 128,
  parameter int W        = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                raw_valid,
  input logic                raw_ready,
  input logic                seed_load,
  input logic                word_valid,
  input logic                word_ready,
  input logic [W-1:0]        word_data,
  input logic [LONG_LEN-1:0] lfsr_q,
  input logic                pp_emit
);
  a_r11_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready |=> word_valid && $stable(word_data));

  a_r11_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready |-> !raw_ready);

  a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  a_r2_lfsr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(raw_valid && raw_ready) && !seed_load |=> $stable(lfsr_q));

  a_r10_word_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> $past(pp_emit));
endmodule

bind rng_mixer_pp rng_mixer_pp_chk #(.LONG_LEN(LONG_LEN), .W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_ready(raw_ready),
  .seed_load(seed_load), .word_valid(word_valid), .word_ready(word_ready),
  .word_data(word_data), .lfsr_q(lfsr_q), .pp_emit(pp_emit)
);

// File: tb/test_rng_mixer_pp.sv
`timescale 1ns/1ps
module test_rng_mixer_pp;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         raw_bit = 1'b0, raw_valid = 1'b0, raw_ready;
  logic [3:0]   out_mode = 4'd4;
  logic [1:0]   pp_mode = 2'd0;
  logic         lfsr_long = 1'b0;
  logic [2:0]   seed_src = 3'd6;
  logic [127:0] user_seed = '0;
  logic         seed_load = 1'b0;
  logic [31:0]  word_data;
  logic         word_valid, word_ready = 1'b0;

  int total = 0, bad = 0, phase_words = 0;
  string tag = "R1";
  bit force_rdy = 1'b0;

  // bench model state
  logic [127:0] m_l, m_h;
  bit m_tog, m_prev, m_acc;
  int m_pc, m_wc;
  logic [31:0] m_word;
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;

  rng_mixer_pp i_rng_mixer_pp (
    .clk(clk), .rst_n(rst_n), .raw_bit(raw_bit), .raw_valid(raw_valid),
    .raw_ready(raw_ready), .out_mode(out_mode), .pp_mode(pp_mode),
    .lfsr_long(lfsr_long), .seed_src(seed_src), .user_seed(user_seed),
    .seed_load(seed_load), .word_data(word_data), .word_valid(word_valid),
    .word_ready(word_ready)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_reset();
    m_l = 128'd1; m_h = '0; m_tog = 0; m_prev = 0; m_acc = 0;
    m_pc = 0; m_wc = 0; m_word = '0; exp_q.delete();
  endtask

  task automatic m_push(input bit b);
    m_word[m_wc] = b;
    if (m_wc == 31) begin exp_q.push_back(m_word); m_wc = 0; end
    else m_wc++;
  endtask

  // expected behaviour per R2 and R4-R10
  task automatic m_step(input bit r);
    bit lo, b, fb;
    lo = lfsr_long ? m_l[127] : m_l[58];
    case (out_mode)
      4'd9: b = lo;
      4'd8: b = lo ^ r;
      4'd7: begin b = m_tog ? r : lo; m_tog = !m_tog; end
      4'd6: begin b = lo ^ r ^ m_prev; m_prev = b; end
      default: b = r;
    endcase
    if (lfsr_long) begin
      fb = m_l[127] ^ m_l[125] ^ m_l[100] ^ m_l[98];
      m_l = {m_l[126:0], fb};
    end else begin
      fb = m_l[58] ^ m_l[57] ^ m_l[37] ^ m_l[36];
      m_l = {69'd0, m_l[57:0], fb};
    end
    m_h = {m_h[126:0], r};
    case (pp_mode)
      2'd0: m_push(b);
      2'd1: begin if (m_pc == 1) m_push(b); m_pc = 1 - m_pc; end
      2'd2: begin
        m_acc = m_acc ^ b;
        if (m_pc == 3) begin m_push(m_acc); m_acc = 0; m_pc = 0; end
        else m_pc++;
      end
      default: begin
        if (m_pc == 0) begin m_acc = b; m_pc = 1; end
        else begin m_pc = 0; if (m_acc != b) m_push(m_acc); end
      end
    endcase
  endtask

  task automatic cyc(input bit v, input bit b);
    logic [31:0] e;
    @(negedge clk);
    raw_valid = v; raw_bit = b;
    word_ready = force_rdy ? 1'b1 : (($urandom % 10) < 7);
    #1;
    if (word_valid && word_ready) begin
      phase_words++;
      if (exp_q.size() == 0) check(0, {tag, " unexpected word"}, word_data, 0);
      else begin
        e = exp_q.pop_front();
        check(word_data == e, {tag, " word"}, word_data, e);
      end
    end
    if (word_valid && !word_ready) check(!raw_ready, "R11 stall", raw_ready, 0);
    if (v && raw_ready) m_step(b);
  endtask

  task automatic drain();
    force_rdy = 1;
    repeat (4) cyc(0, 0);
    force_rdy = 0;
    check(exp_q.size() == 0, {tag, " all words delivered"}, exp_q.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; raw_valid = 0; seed_load = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_reset();
  endtask

  task automatic load_seed(input logic [2:0] src, input logic [127:0] s);
    logic [127:0] v;
    drain();
    @(negedge clk);
    seed_src = src; user_seed = s; seed_load = 1; raw_valid = 0;
    v = (src == 3'd4) ? m_h : s;
    if (!lfsr_long) v = v & {69'd0, {59{1'b1}}};
    m_l = (v == '0) ? 128'd1 : v;
    @(negedge clk);
    seed_load = 0;
  endtask

  task automatic run(input string t, input logic [3:0] om, input logic [1:0] pm,
                     input bit lg, input int n, input bit const_in, input bit cval);
    tag = t; out_mode = om; pp_mode = pm; lfsr_long = lg; phase_words = 0;
    for (int i = 0; i < n; i++) begin
      bit v, b;
      v = const_in ? 1'b1 : (($urandom % 8) != 0);
      b = const_in ? cval : 1'($urandom);
      cyc(v, b);
    end
    drain();
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_reset();
    repeat (3) @(negedge clk);
    #1;
    check(word_valid == 0, "R1 reset word_valid", word_valid, 0);
    check(raw_ready == 1, "R1 reset raw_ready", raw_ready, 1);
    rst_n = 1;

    // R1: LFSR starts at 1 (short, mode 9, no seed load)
    run("R1", 4'd9, 2'd0, 0, 700, 0, 0);
    do_reset();
    run("R4 raw R7 none R10", 4'd4, 2'd0, 0, 800, 0, 0);
    do_reset();
    lfsr_long = 1;
    load_seed(3'd6, {$urandom, $urandom, $urandom, $urandom});
    run("R2 R3 long lfsr", 4'd9, 2'd0, 1, 900, 0, 0);
    do_reset();
    load_seed(3'd6, {$urandom, $urandom, $urandom, $urandom});
    run("R4 xor R7 skip", 4'd8, 2'd1, 0, 1200, 0, 0);
    do_reset();
    run("R5 alt R8 count", 4'd7, 2'd2, 1, 1800, 0, 0);
    do_reset();
    run("R6 parity R9 vn", 4'd6, 2'd3, 0, 1800, 0, 0);
    do_reset();
    run("R4 unlisted code", 4'd5, 2'd0, 0, 500, 0, 0);
    // R3: history seed after raw stream, long then short
    do_reset();
    run("R3 hist fill", 4'd4, 2'd0, 1, 300, 0, 0);
    lfsr_long = 1;
    load_seed(3'd4, '0);
    run("R3 hist seed long", 4'd9, 2'd0, 1, 400, 0, 0);
    lfsr_long = 0;
    load_seed(3'd4, '0);
    run("R3 hist seed short", 4'd9, 2'd1, 0, 400, 0, 0);
    // R3: zero seed replaced by 1 (upper bits masked off in short mode)
    do_reset();
    lfsr_long = 0;
    load_seed(3'd6, {69'h1F, 59'd0});
    run("R3 zero seed", 4'd9, 2'd0, 0, 300, 0, 0);
    // R9: equal pairs only, no words at all
    do_reset();
    run("R9 constant", 4'd4, 2'd3, 0, 400, 1, 1);
    check(phase_words == 0, "R9 no words from equal pairs", phase_words, 0);
    // R11: heavy stall phase
    do_reset();
    run("R11 backpressure", 4'd8, 2'd0, 1, 900, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule